// File: doc/BRIEF.md
# Fractional-Rate Clock Enable Controller

The block derives a clock enable from its own clock (the parent) so that, on average, the enable is high for `mult` out of every 32 parent cycles. The `mult` value ranges from 1 to 32. The enable comes from a pulse-swallowing accumulator. On each parent cycle the multiplier is added to a 5-bit phase register, and every carry out of the register produces one enable pulse. Logic downstream qualifies its flops with this enable. That gives it a slowed, evenly spread activity rate without a second clock.

Software controls the block through a small register window with two words.

- **Ratio word.** It holds a 5-bit field in bits 12:8. The field stores 32 minus the desired multiplier, so a field of 0 gives full rate.
- **Commit word.** Its bit 31 is a commit flag. Writing the ratio word only fills a shadow copy. Writing 1 to bit 31 starts a commit handshake. The flag then stays set through a fixed synchronisation delay and then until the next accumulator wrap. At that wrap the active multiplier is loaded from the shadow and the flag clears by itself.

Software polls the flag until it reads 0. A generous limit of 1000 polls is enough. While the flag is set, new ratio writes and new commit requests are refused.

Top module: `fracclk_ctrl`

## Requirements
- R1: While reset is held, `busy` and `clk_en` are low. After reset, the ratio word reads 0, bit 31 of the commit word reads 0, and the active multiplier is 32, so `clk_en` is high on every cycle.
- R2: A write at the ratio offset (0x00) stores `wdata[12:8]` in the shadow field. A read at that offset returns the field in bits 12:8 and 0 in every other bit.
- R3: Within any 32 consecutive cycles in which the active field `f` does not change, `clk_en` is high on exactly `32 - f` cycles.
- R4: Writing the ratio word without a commit leaves the output rate unchanged.
- R5: A write at the commit offset (0x04) with bit 31 set, made while idle, makes `busy` and commit-word bit 31 read 1 from the next cycle on. A write with bit 31 clear has no effect.
- R6: After a commit, the flag reads 1 for at least SYNC_CYC+1 (5) and at most SYNC_CYC+32 (36) cycles and then reads 0. From then on, the output rate follows the committed field.
- R7: While the flag is set, writes to the ratio word are ignored and further commit requests are ignored. The flag does not restart after it clears.
- R8: The new ratio takes effect only on an accumulator wrap. On the first cycle in which the flag reads 0 again, `clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| clk_en | output | 1 | Derived clock enable |
| busy | output | 1 | Commit in progress (mirrors commit-word bit 31) |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 5-bit accumulator and a 4-cycle synchronisation delay. With these values every ratio from 1/32 to 32/32 can be reached. Because the denominator is small, the exact rate identity can be checked over a 32-cycle window. The same small denominator keeps the worst-case commit wait, which happens at a field of 31, down to 36 cycles, well inside the poll limit. Random fields are mixed with the extreme fields 0 and 31, and with writes and commit attempts made while the flag is still set.

// File: rtl/fracclk_pkg.sv
// Package: shared constants and types for the fractional-rate clock enable
// controller. Assumes a 32-bit register data path.
package fracclk_pkg;
    localparam int DATA_W    = 32;
    localparam int RATIO_OFS = 0;   // ratio word byte offset
    localparam int KICK_OFS  = 4;   // commit word byte offset
    localparam int FIELD_LSB = 8;   // ratio field position in the ratio word
    localparam int KICK_BIT  = 31;  // commit flag position in the commit word

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_SYNC = 2'd1,
        KS_WAIT = 2'd2
    } kick_state_t;
endpackage

// File: rtl/fracclk_regs.sv
// Register window: decodes writes to the ratio and commit words, holds the
// shadow ratio field and returns read data. Assumes busy_i comes from the
// commit state machine; every write is refused while it is high.
module fracclk_regs
    import fracclk_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               busy_i,
    output logic [DATA_W-1:0]  rdata,
    output logic [FIELD_W-1:0] shadow_o,
    output logic               kick_req_o
);
    logic               ratio_hit;
    logic               kick_hit;
    logic               ratio_wr;
    logic [FIELD_W-1:0] shadow_q;

    assign ratio_hit  = (addr == ADDR_W'(RATIO_OFS));
    assign kick_hit   = (addr == ADDR_W'(KICK_OFS));
    assign ratio_wr   = wr_en && ratio_hit && !busy_i;
    assign kick_req_o = wr_en && kick_hit && wdata[KICK_BIT] && !busy_i;
    assign shadow_o   = shadow_q;

    // Capture the shadow ratio field on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (ratio_wr)
            shadow_q <= wdata[FIELD_LSB +: FIELD_W];
    end

    // Return the addressed word; bits with no storage read as zero.
    always_comb begin
        rdata = '0;
        if (ratio_hit)
            rdata[FIELD_LSB +: FIELD_W] = shadow_q;
        else if (kick_hit)
            rdata[KICK_BIT] = busy_i;
    end

    // R7
    shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> $stable(shadow_q));

    // R5
    kick_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_req_o |=> busy_i);
endmodule

// File: rtl/fracclk_kick.sv
// Commit handshake: on a request it holds busy through SYNC_CYC cycles of
// synchronisation, then waits for the accumulator carry and pulses load in
// that cycle. Assumes kick_req_i is only raised while idle.
module fracclk_kick
    import fracclk_pkg::*;
#(
    parameter int SYNC_CYC = 4,
    parameter int DEN      = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req_i,
    input  logic carry_i,
    output logic busy_o,
    output logic load_o
);
    localparam int CNT_W = $clog2(SYNC_CYC + 1);
    localparam int LEN_W = $clog2(SYNC_CYC + DEN + 2);

    kick_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] busy_len_q;

    assign busy_o = (state_q != KS_IDLE);
    assign load_o = (state_q == KS_WAIT) && carry_i;

    // Step the handshake: idle -> sync delay -> wait for wrap -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                KS_IDLE: if (kick_req_i) begin
                    state_q <= KS_SYNC;
                    cnt_q   <= '0;
                end
                KS_SYNC: begin
                    if (cnt_q == CNT_W'(SYNC_CYC - 1))
                        state_q <= KS_WAIT;
                    cnt_q <= cnt_q + 1'b1;
                end
                KS_WAIT: if (carry_i) state_q <= KS_IDLE;
                default: state_q <= KS_IDLE;
            endcase
        end
    end

    // Checker counter: length of the current busy interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_len_q <= '0;
        else if (busy_o)
            busy_len_q <= busy_len_q + 1'b1;
        else
            busy_len_q <= '0;
    end

    // R6
    busy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len_q <= LEN_W'(SYNC_CYC + DEN));

    // R6
    busy_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && busy_len_q != '0) |-> (busy_len_q >= LEN_W'(SYNC_CYC + 1)));

    // R8
    clear_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(carry_i));
endmodule

// File: rtl/fracclk_accum.sv
// Pulse-swallowing accumulator: adds the active multiplier (2**ACC_W minus
// the active field) each cycle and registers the carry as the enable. The
// active field reloads from the shadow when load_i is high.
module fracclk_accum #(
    parameter int ACC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ACC_W-1:0] shadow_i,
    output logic             carry_o,
    output logic             clk_en_o
);
    localparam int DEN = 1 << ACC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] act_field_q;
    logic [ACC_W:0]   mult;
    logic [ACC_W:0]   sum;

    assign mult    = (ACC_W+1)'(DEN) - {1'b0, act_field_q};
    assign sum     = {1'b0, acc_q} + mult;
    assign carry_o = sum[ACC_W];

    // Advance the phase and register the carry as the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            clk_en_o <= 1'b0;
        end else begin
            acc_q    <= sum[ACC_W-1:0];
            clk_en_o <= carry_o;
        end
    end

    // Reload the active field from the shadow on a committed wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_field_q <= '0;
        else if (load_i)
            act_field_q <= shadow_i;
    end

    // R8
    ratio_moves_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_field_q != $past(act_field_q)) |-> $past(load_i));

    // R3
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(act_field_q) == '0) |-> clk_en_o);
endmodule

// File: rtl/fracclk_ctrl.sv
// Top: fractional-rate clock enable controller. It joins the register window,
// the commit handshake and the accumulator. Assumes a single clock domain and
// software that polls busy (commit bit) before writing new values.
module fracclk_ctrl
    import fracclk_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int ACC_W    = 5,
    parameter int SYNC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              clk_en,
    output logic              busy
);
    localparam int DEN = 1 << ACC_W;

    logic [ACC_W-1:0] shadow;
    logic             kick_req;
    logic             carry;
    logic             load;

    fracclk_regs #(.ADDR_W(ADDR_W), .FIELD_W(ACC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .busy_i     (busy),
        .rdata      (rdata),
        .shadow_o   (shadow),
        .kick_req_o (kick_req)
    );

    fracclk_kick #(.SYNC_CYC(SYNC_CYC), .DEN(DEN)) u_kick (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_req_i (kick_req),
        .carry_i    (carry),
        .busy_o     (busy),
        .load_o     (load)
    );

    fracclk_accum #(.ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .shadow_i (shadow),
        .carry_o  (carry),
        .clk_en_o (clk_en)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !clk_en));
endmodule

// File: tb/sim_fracclk_ctrl.sv
`timescale 1ns/1ps
module sim_fracclk_ctrl;
    localparam int ADDR_W   = 8;
    localparam int ACC_W    = 5;
    localparam int SYNC_CYC = 4;
    localparam int DEN      = 32;
    localparam logic [7:0] A_RATIO = 8'h00;
    localparam logic [7:0] A_KICK  = 8'h04;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              clk_en;
    logic              busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int cur_mult = DEN;

    always #2.5 clk = ~clk;

    fracclk_ctrl #(.ADDR_W(ADDR_W), .ACC_W(ACC_W), .SYNC_CYC(SYNC_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .clk_en(clk_en), .busy(busy)
    );

    function automatic int exp_mult(input int f);
        return DEN - f;
    endfunction

    function automatic logic [31:0] exp_ratio_word(input logic [31:0] w);
        return ((w >> 8) & 32'h1F) << 8;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] q);
        addr = a;
        #1 q = rdata;
    endtask

    task automatic count_win(output int c);
        repeat (2) @(negedge clk);
        c = 0;
        repeat (DEN) begin
            @(negedge clk);
            if (clk_en) c++;
        end
    endtask

    // Commit and poll; optionally try a ratio write and a second commit mid-way.
    task automatic kick_wait(input bit poke, input int poke_f,
                             output int nbusy, output bit en_at_clear);
        bit cleared = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; addr = A_KICK; wdata = 32'h8000_0000;
        nbusy = 0; en_at_clear = 1'b0;
        for (int i = 0; i < 1000 && !cleared; i++) begin
            @(negedge clk);
            wr_en = 1'b0; wdata = '0; addr = A_KICK;
            #1;
            if (i == 0) begin
                chk("R5 commit bit set after commit", int'(rdata[31]), 1);
                chk("R5 busy set after commit", int'(busy), 1);
            end
            if (rdata[31]) begin
                nbusy++;
                if (poke && nbusy == 2) begin
                    wr_en = 1'b1; addr = A_RATIO; wdata = 32'(poke_f) << 8;
                end
                if (poke && nbusy == 3) begin
                    wr_en = 1'b1; addr = A_KICK; wdata = 32'h8000_0000;
                end
            end else begin
                cleared = 1'b1;
                en_at_clear = clk_en;
            end
        end
        if (!cleared) chk("R6 commit timeout", 0, 1);
    endtask

    task automatic step(input int f, input bit poke);
        logic [31:0] w, q;
        int c, nb;
        bit en;
        w = (32'(f) << 8) | ($urandom & ~32'h0000_1F00);
        wr(A_RATIO, w);
        rd(A_RATIO, q);
        chk("R2 ratio readback", int'(q), int'(exp_ratio_word(w)));
        count_win(c);
        chk("R4 rate unchanged before commit", c, cur_mult);
        kick_wait(poke, (f + 7) % DEN, nb, en);
        chk("R6 busy at least SYNC_CYC+1", int'(nb >= SYNC_CYC + 1), 1);
        chk("R6 busy at most SYNC_CYC+32", int'(nb <= SYNC_CYC + DEN), 1);
        chk("R8 enable high on clearing cycle", int'(en), 1);
        if (poke) begin
            rd(A_RATIO, q);
            chk("R7 shadow kept while busy", int'(q), f << 8);
            @(negedge clk);
            chk("R7 second commit refused", int'(busy), 0);
        end
        count_win(c);
        chk("R3 R6 rate after commit", c, exp_mult(f));
        cur_mult = exp_mult(f);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [31:0] q;
        int c;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        chk("R1 busy low in reset", int'(busy), 0);
        chk("R1 clk_en low in reset", int'(clk_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_RATIO, q);
        chk("R1 ratio word after reset", int'(q), 0);
        rd(A_KICK, q);
        chk("R1 commit word after reset", int'(q), 0);
        count_win(c);
        chk("R1 full rate after reset", c, DEN);

        wr(A_KICK, 32'h7FFF_FFFF);
        chk("R5 bit31 clear no busy", int'(busy), 0);
        rd(A_KICK, q);
        chk("R5 bit31 clear reads 0", int'(q), 0);

        step(31, 1'b1);
        step(0, 1'b0);
        step(31, 1'b0);
        step(16, 1'b1);
        step(1, 1'b0);
        for (int k = 0; k < 12; k++)
            step($urandom_range(0, 31), k[0]);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R6 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule